// File: doc/BRIEF.md
# External Bus Request/Grant Controller

This block decides who owns a shared external memory bus: the internal requesters (core fetches, core data accesses, peripheral and DMA traffic) or a single outside master. The outside master raises an asynchronous request line. The block synchronises that line and hands the bus over only when nothing inside needs it. While the bus is handed over, the block drops the enables of the address, data, select-strobe and read/write-strobe drivers so the pads float. Any internal access that wants external space in that time is stalled, and a hang flag tells the outside master that an internal access is waiting.

The outside request always has the lowest priority. A grant is also withheld in three other cases: an internal access is still in flight, the current instruction still has a second back-to-back external read to issue, or the core-exclusive lock is set. Once the bus has been handed over, it comes back only when the outside master drops its request. The grant then falls and the drivers are re-enabled on the same clock edge, and the stalled accesses carry on. The block has its own power-on reset, separate from the core reset, so request handling keeps working while the core is held in reset or is booting.

Top module: `ebus_grant_ctrl`

## Requirements
- R1: A new grant is issued only in a cycle where no bit of `int_req_i` is set. The outside request has the lowest priority.
- R2: With nothing blocking, `ext_grant_o` rises SYNC_STAGES+1 clock cycles after `ext_req_i` goes high. With the default of 2 this is three cycles, and the grant is still low after two cycles.
- R3: `drv_en_o` has one bit per driver group, and 1 means the drivers are active. Every bit equals the inverse of `ext_grant_o` in every cycle. After reset, `ext_grant_o` is 0 and all `drv_en_o` bits are 1.
- R4: While granted, `int_stall_o[i]` is 1 exactly when `int_req_i[i]` is 1, and `grant_hang_o` is 1 when any request bit is set. While not granted, both outputs are 0.
- R5: While `atomic_hold_i` is 1 (a second external read of the same instruction is pending), no new grant is issued. Once it clears, the grant follows one cycle later.
- R6: While `excl_lock_i` is 1, no new grant is issued. Once it clears, the grant follows one cycle later.
- R7: When `ext_req_i` falls, `ext_grant_o` falls SYNC_STAGES+1 cycles later, on the same edge as `drv_en_o` returns to all ones. From that cycle the stalls are released.
- R8: While `acc_busy_i` is 1 (an internal access is in progress), no new grant is issued. Once it clears, the grant follows one cycle later.
- R9: Once granted, the grant stays high while `ext_req_i` stays high, even if internal requests or the lock bit appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low power-on reset of this block only |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master |
| int_req_i | input | NUM_INT | Internal requesters with an external-space access ready |
| acc_busy_i | input | 1 | An internal external access is in progress |
| atomic_hold_i | input | 1 | The current instruction has a second external read pending |
| excl_lock_i | input | 1 | Core-exclusive configuration bit |
| ext_grant_o | output | 1 | Bus granted to the outside master |
| grant_hang_o | output | 1 | An internal access is held off by the grant |
| drv_en_o | output | DRV_GROUPS | Driver enables for the address, data, select and strobe groups |
| int_stall_o | output | NUM_INT | Per-requester stall |

## Verification
Every cycle, the checker confirms the following. A grant never rises after a cycle with an internal request, a busy access, an atomic hold or the lock set. With two synchroniser stages, the grant rises and falls only three cycles after the matching request level. The driver enables always mirror the grant, and the stall and hang outputs are seen only while the bus is granted. Only the bench scenarios show the following: the exact latency in both directions, the one-cycle hand-over after each blocker clears, the grant staying up when internal requests or the lock appear, and the reset state.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic {
      OWN_INT = 1'b0,
      OWN_EXT = 1'b1
   } owner_e;
endpackage

// File: rtl/ebus_sync.sv
module ebus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ebus_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ebus_arb.sv
module ebus_arb
   import ebus_pkg::*;
#(
   parameter int NUM_INT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_sync_i,
   input  logic [NUM_INT-1:0] int_req_i,
   input  logic               acc_busy_i,
   input  logic               atomic_hold_i,
   input  logic               excl_lock_i,
   output logic               grant_o,
   output logic               grant_nxt_o
);
   owner_e owner_q, owner_d;
   logic   blocked;

   // any internal claim, in-flight access, atomic pair or lock withholds a new grant
   assign blocked = (|int_req_i) | acc_busy_i | atomic_hold_i | excl_lock_i;

   always_comb begin
      owner_d = owner_q;
      unique case (owner_q)
         OWN_INT: if (req_sync_i && !blocked) owner_d = OWN_EXT;
         OWN_EXT: if (!req_sync_i)            owner_d = OWN_INT;
         default: owner_d = OWN_INT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) owner_q <= OWN_INT;
      else        owner_q <= owner_d;

   assign grant_o     = (owner_q == OWN_EXT);
   assign grant_nxt_o = (owner_d == OWN_EXT);
endmodule

// File: rtl/ebus_drv.sv
module ebus_drv #(
   parameter int GROUPS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_nxt_i,
   output logic [GROUPS-1:0] drv_en_o
);
   generate
      if (GROUPS < 1) begin : g_bad
         $error("ebus_drv: GROUPS must be at least 1");
      end
      // one enable flop per pad group to keep fanout local
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) drv_en_o[g] <= 1'b1;
            else        drv_en_o[g] <= ~grant_nxt_i;
      end
   endgenerate
endmodule

// File: rtl/ebus_grant_ctrl.sv
module ebus_grant_ctrl #(
   parameter int NUM_INT     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DRV_GROUPS  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ext_req_i,
   input  logic [NUM_INT-1:0]    int_req_i,
   input  logic                  acc_busy_i,
   input  logic                  atomic_hold_i,
   input  logic                  excl_lock_i,
   output logic                  ext_grant_o,
   output logic                  grant_hang_o,
   output logic [DRV_GROUPS-1:0] drv_en_o,
   output logic [NUM_INT-1:0]    int_stall_o
);
   logic req_sync;
   logic grant_nxt;

   generate
      if (NUM_INT < 1) begin : g_bad_int
         $error("ebus_grant_ctrl: NUM_INT must be at least 1");
      end
   endgenerate

   ebus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_req_i),
      .sync_o  (req_sync)
   );

   ebus_arb #(.NUM_INT(NUM_INT)) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_sync_i    (req_sync),
      .int_req_i     (int_req_i),
      .acc_busy_i    (acc_busy_i),
      .atomic_hold_i (atomic_hold_i),
      .excl_lock_i   (excl_lock_i),
      .grant_o       (ext_grant_o),
      .grant_nxt_o   (grant_nxt)
   );

   ebus_drv #(.GROUPS(DRV_GROUPS)) u_drv (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_nxt_i (grant_nxt),
      .drv_en_o    (drv_en_o)
   );

   assign int_stall_o  = int_req_i & {NUM_INT{ext_grant_o}};
   assign grant_hang_o = |int_stall_o;
endmodule

// File: rtl/ebus_grant_chk.sv
module ebus_grant_chk #(
   parameter int NUM_INT     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DRV_GROUPS  = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ext_req_i,
   input logic [NUM_INT-1:0]    int_req_i,
   input logic                  acc_busy_i,
   input logic                  atomic_hold_i,
   input logic                  excl_lock_i,
   input logic                  ext_grant_o,
   input logic                  grant_hang_o,
   input logic [DRV_GROUPS-1:0] drv_en_o,
   input logic [NUM_INT-1:0]    int_stall_o
);
   assert_lowest_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_grant_o) |-> $past(int_req_i) == '0);

   assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_grant_o) |-> !$past(acc_busy_i));

   assert_atomic_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_grant_o) |-> !$past(atomic_hold_i));

   assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_grant_o) |-> !$past(excl_lock_i));

   assert_drv_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o == {DRV_GROUPS{~ext_grant_o}});

   assert_stall_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_hang_o || (int_stall_o != '0)) |-> ext_grant_o);

   assert_hang_when_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_grant_o && (int_req_i != '0)) |-> grant_hang_o);

   generate
      if (SYNC_STAGES == 2) begin : g_lat
         assert_grant_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ext_grant_o) |-> $past(ext_req_i, 3));
         assert_release_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ext_grant_o) |-> !$past(ext_req_i, 3));
      end
   endgenerate
endmodule

bind ebus_grant_ctrl ebus_grant_chk #(
   .NUM_INT     (NUM_INT),
   .SYNC_STAGES (SYNC_STAGES),
   .DRV_GROUPS  (DRV_GROUPS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ext_req_i     (ext_req_i),
   .int_req_i     (int_req_i),
   .acc_busy_i    (acc_busy_i),
   .atomic_hold_i (atomic_hold_i),
   .excl_lock_i   (excl_lock_i),
   .ext_grant_o   (ext_grant_o),
   .grant_hang_o  (grant_hang_o),
   .drv_en_o      (drv_en_o),
   .int_stall_o   (int_stall_o)
);

// File: tb/ebus_grant_ctrl_test.sv
`timescale 1ns/1ps
module ebus_grant_ctrl_test;
   localparam int NI = 2;
   localparam int NG = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_req = 1'b0;
   logic [NI-1:0] int_req = '0;
   logic          acc_busy = 1'b0;
   logic          atomic_hold = 1'b0;
   logic          excl_lock = 1'b0;
   logic          grant, hang;
   logic [NG-1:0] drv_en;
   logic [NI-1:0] stall;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   typedef struct {
      int            cyc;
      logic          g;
      logic          h;
      logic [NI-1:0] st;
      string         tag;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ebus_grant_ctrl #(.NUM_INT(NI), .SYNC_STAGES(2), .DRV_GROUPS(NG)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_req_i     (ext_req),
      .int_req_i     (int_req),
      .acc_busy_i    (acc_busy),
      .atomic_hold_i (atomic_hold),
      .excl_lock_i   (excl_lock),
      .ext_grant_o   (grant),
      .grant_hang_o  (hang),
      .drv_en_o      (drv_en),
      .int_stall_o   (stall)
   );

   task automatic push(input int c, input logic g, input logic h,
                       input logic [NI-1:0] st, input string tag);
      exp_t e;
      e.cyc = c; e.g = g; e.h = h; e.st = st; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares outputs at the falling edge of the cycle each item names
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (e.cyc < cyc) begin
            n_bad++;
            $display("FAIL %s: item for cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
         end else if (grant !== e.g || hang !== e.h || stall !== e.st ||
                      drv_en !== {NG{~e.g}}) begin
            n_bad++;
            $display("FAIL %s @%0d: grant=%b hang=%b stall=%b drv=%b exp grant=%b hang=%b stall=%b drv=%b",
                     e.tag, cyc, grant, hang, stall, drv_en, e.g, e.h, e.st, {NG{~e.g}});
         end
      end
   end

   // kind: 0 internal request, 1 busy access, 2 atomic hold, 3 lock
   task automatic set_block(input int kind, input logic v);
      case (kind)
         0: int_req[0] = v;
         1: acc_busy   = v;
         2: atomic_hold = v;
         default: excl_lock = v;
      endcase
   endtask

   task automatic blocker_case(input int kind, input string tag);
      int c;
      @(negedge clk);
      c = cyc;
      set_block(kind, 1'b1);
      ext_req = 1'b1;
      push(c + 3, 1'b0, 1'b0, '0, {tag, " blocked at latency"});
      push(c + 8, 1'b0, 1'b0, '0, {tag, " still blocked"});
      repeat (10) @(negedge clk);
      c = cyc;
      set_block(kind, 1'b0);
      push(c + 1, 1'b1, 1'b0, '0, {tag, " grant after clear"});
      repeat (3) @(negedge clk);
      c = cyc;
      ext_req = 1'b0;
      push(c + 3, 1'b0, 1'b0, '0, {tag, " released"});
      repeat (6) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      int c;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      c = cyc;
      push(c + 1, 1'b0, 1'b0, '0, "R3 reset state");
      repeat (3) @(negedge clk);

      // R2 latency, R3 drivers, R4 stall/hang, R9 grant kept, R7 release
      c = cyc;
      ext_req = 1'b1;
      push(c + 2, 1'b0, 1'b0, '0, "R2 not yet granted");
      push(c + 3, 1'b1, 1'b0, '0, "R2 granted, R3 drivers off");
      repeat (5) @(negedge clk);
      c = cyc;
      int_req = 2'b01;
      excl_lock = 1'b1;
      push(c + 1, 1'b1, 1'b1, 2'b01, "R4 stall while granted");
      push(c + 3, 1'b1, 1'b1, 2'b01, "R9 grant kept under lock");
      repeat (4) @(negedge clk);
      c = cyc;
      int_req = 2'b11;
      ext_req = 1'b0;
      push(c + 2, 1'b1, 1'b1, 2'b11, "R7 held before latency");
      push(c + 3, 1'b0, 1'b0, 2'b00, "R7 released, R4 stalls clear");
      repeat (4) @(negedge clk);
      int_req = '0;
      excl_lock = 1'b0;
      repeat (4) @(negedge clk);

      blocker_case(0, "R1");
      blocker_case(1, "R8");
      blocker_case(2, "R5");
      blocker_case(3, "R6");

      // short request pulse still honours the same latency in both directions
      @(negedge clk);
      c = cyc;
      ext_req = 1'b1;
      @(negedge clk);
      ext_req = 1'b0;
      push(c + 3, 1'b1, 1'b0, '0, "R2 one-cycle pulse grant");
      push(c + 4, 1'b0, 1'b0, '0, "R7 one-cycle pulse release");
      repeat (8) @(negedge clk);

      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R3: %0d expected items left unchecked (exp 0)", q.size());
      end
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2: watchdog expired at cycle %0d (exp run end)", cyc);
         finish_run();
      end
   end
endmodule